// File: doc/BRIEF.md
# Iterative CAM Packet Classifier

This block classifies a packet as its bytes stream past, one byte per cycle. Each byte is joined with a small tag, which is the state carried over from the previous step, to form a lookup key. The key is presented to a ternary content-addressable memory, and the index of the winning entry is the step's outcome. That index selects a word in a writable control store. The control word decides three things: which tag accompanies the next byte, how many following bytes to pass over, and whether classification stops here. Programmed this way, the memory behaves as a state machine that walks the packet.

Classification stops in one of three ways: a control word says it is done, no entry matches, or the packet's last byte arrives. The block then pulses a result strobe with the index of the final successful match and a miss flag. Any bytes that remain in the packet after that point are ignored. The next packet begins with the first valid byte after a last byte. A host fills the memory and the control store through simple write ports.

Top module: `camClassifier`

## Requirements
- R1: The first byte of every packet is looked up with a tag of zero. Later lookups use the tag chosen by the previous match. A key is laid out with the tag in bits [12:8] and the byte in bits [7:0].
- R2: An entry matches only if it is enabled and its key equals the lookup key on every bit where its mask bit is 1. Bits where the mask is 0 are ignored. A disabled entry never matches.
- R3: When several entries match, the entry with the lowest index wins.
- R4: The control word is laid out as [10] done, [9] tag override, [8:4] tag, [3:0] skip count. After a match, the next tag is the matching index, or the tag field when the override bit is 1.
- R5: A match whose control word has done set ends classification. The reported index is that match and the miss flag is 0.
- R6: A lookup that matches no entry ends classification with the miss flag set to 1. The reported index is the last successful match of the packet, or 0 if there was none.
- R7: A last byte that does not end classification in any other way ends it with the miss flag 0 and the last successful match reported.
- R8: After a match with skip count N, the next N valid bytes are not looked up and do not change the tag. A last byte among them still ends classification (R7).
- R9: The result strobe is high for exactly one cycle, in the cycle after the clock edge that accepted the ending byte. Bytes after an early end are ignored up to and including the packet's last byte, and the following byte starts a new packet.
- R10: After reset, the result strobe is low and every entry is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byteValid | input | 1 | Packet byte present this cycle |
| byteData | input | 8 | Packet byte |
| byteLast | input | 1 | Byte is the packet's last |
| camWrEn | input | 1 | Write one CAM entry |
| camWrAddr | input | 5 | Entry index to write |
| camWrValid | input | 1 | Enable flag for the written entry |
| camWrKey | input | 13 | Key for the written entry |
| camWrMask | input | 13 | Care mask for the written entry (1 = compare) |
| ctlWrEn | input | 1 | Write one control word |
| ctlWrAddr | input | 5 | Control word index |
| ctlWrData | input | 11 | Control word value |
| resultValid | output | 1 | Classification result strobe |
| resultHit | output | 5 | Index of the final successful match |
| resultMiss | output | 1 | Classification ended on a failed lookup |

## Verification
The bench builds the block with its default parameters: 32 entries, 8-bit bytes and a 4-bit skip count. With these values every one of the 32 entries and tags can be programmed and hit. A single-byte packet can be swept through all 256 byte values against a chosen table, so each entry's selection, the ternary masking and the lowest-index priority are checked against arithmetic predictions for every byte. The skip count is swept over its full range of 0 to 15, and multi-byte chains exercise tag feedback, tag override, a mid-packet miss and the ignoring of trailing bytes.

// File: rtl/clsPkg.sv
package clsPkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic lookup;  // perform a CAM lookup with this byte
    logic first;   // lookup is the packet's first (tag forced to zero)
    logic skip;    // consume this byte as a skipped byte
    logic emit;    // classification ends on this byte
  } clsStrobeT;

  // Status from the datapath to the control FSM
  typedef struct packed {
    logic hit;          // current lookup matched an entry
    logic done;         // control word of the match requests completion
    logic skipPending;  // bytes remain to be skipped
  } clsStatusT;

endpackage

// File: rtl/clsCam.sv
module clsCam #(
  parameter int ENTRIES = 32,
  parameter int KEY_W   = 13,
  localparam int ADDR_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrValid,
  input  logic [KEY_W-1:0]  wrKey,
  input  logic [KEY_W-1:0]  wrMask,
  input  logic [KEY_W-1:0]  refKey,
  output logic              hit,
  output logic [ADDR_W-1:0] hitAddr
);

  logic [KEY_W-1:0] keyMem  [ENTRIES];
  logic [KEY_W-1:0] maskMem [ENTRIES];
  logic [ENTRIES-1:0] entValid;
  logic [ENTRIES-1:0] matchVec;

  always_ff @(posedge clk) begin
    if (rst) begin
      entValid <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        keyMem[e]  <= '0;
        maskMem[e] <= '0;
      end
    end else if (wrEn) begin
      entValid[wrAddr] <= wrValid;
      keyMem[wrAddr]   <= wrKey;
      maskMem[wrAddr]  <= wrMask;
    end
  end

  // Ternary compare, one comparator per entry
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign matchVec[e] = entValid[e] && (((refKey ^ keyMem[e]) & maskMem[e]) == '0);
  end

  // Lowest index wins
  always_comb begin
    hit     = |matchVec;
    hitAddr = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (matchVec[e]) hitAddr = ADDR_W'(e);
    end
  end

endmodule

// File: rtl/clsCtlStore.sv
module clsCtlStore #(
  parameter int ENTRIES = 32,
  parameter int CW_W    = 11,
  localparam int ADDR_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CW_W-1:0]   wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CW_W-1:0]   rdData
);

  logic [CW_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENTRIES; e++) mem[e] <= '0;
    end else if (wrEn) begin
      mem[wrAddr] <= wrData;
    end
  end

  assign rdData = mem[rdAddr];

endmodule

// File: rtl/clsDatapath.sv
module clsDatapath
  import clsPkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int BYTE_W  = 8,
  parameter int SKIP_W  = 4,
  localparam int ADDR_W = $clog2(ENTRIES),
  localparam int KEY_W  = ADDR_W + BYTE_W,
  localparam int CW_W   = 2 + ADDR_W + SKIP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              camWrEn,
  input  logic [ADDR_W-1:0] camWrAddr,
  input  logic              camWrValid,
  input  logic [KEY_W-1:0]  camWrKey,
  input  logic [KEY_W-1:0]  camWrMask,
  input  logic              ctlWrEn,
  input  logic [ADDR_W-1:0] ctlWrAddr,
  input  logic [CW_W-1:0]   ctlWrData,
  input  clsStrobeT         strb,
  output clsStatusT         stat,
  output logic              resultValid,
  output logic [ADDR_W-1:0] resultHit,
  output logic              resultMiss
);

  logic [ADDR_W-1:0] prevTag;
  logic [ADDR_W-1:0] lastHit;
  logic [SKIP_W-1:0] skipCnt;
  logic [ADDR_W-1:0] refTag;
  logic [KEY_W-1:0]  refKey;
  logic              camHit;
  logic [ADDR_W-1:0] camHitAddr;
  logic [CW_W-1:0]   ctlWord;
  logic              cwDone;
  logic              cwUseTag;
  logic [ADDR_W-1:0] cwTag;
  logic [SKIP_W-1:0] cwSkip;
  logic [ADDR_W-1:0] nextLast;

  assign refTag = strb.first ? '0 : prevTag;
  assign refKey = {refTag, byteData};

  clsCam #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) cam_i (
    .clk(clk), .rst(rst),
    .wrEn(camWrEn), .wrAddr(camWrAddr), .wrValid(camWrValid),
    .wrKey(camWrKey), .wrMask(camWrMask),
    .refKey(refKey), .hit(camHit), .hitAddr(camHitAddr)
  );

  clsCtlStore #(.ENTRIES(ENTRIES), .CW_W(CW_W)) store_i (
    .clk(clk), .rst(rst),
    .wrEn(ctlWrEn), .wrAddr(ctlWrAddr), .wrData(ctlWrData),
    .rdAddr(camHitAddr), .rdData(ctlWord)
  );

  assign cwDone   = ctlWord[CW_W-1];
  assign cwUseTag = ctlWord[CW_W-2];
  assign cwTag    = ctlWord[SKIP_W +: ADDR_W];
  assign cwSkip   = ctlWord[SKIP_W-1:0];

  assign stat.hit         = camHit;
  assign stat.done        = cwDone;
  assign stat.skipPending = (skipCnt != '0);

  always_comb begin
    nextLast = lastHit;
    if (strb.lookup) begin
      if (camHit)          nextLast = camHitAddr;
      else if (strb.first) nextLast = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevTag     <= '0;
      lastHit     <= '0;
      skipCnt     <= '0;
      resultValid <= 1'b0;
      resultHit   <= '0;
      resultMiss  <= 1'b0;
    end else begin
      resultValid <= strb.emit;
      if (strb.emit) begin
        resultHit  <= nextLast;
        resultMiss <= strb.lookup && !camHit;
      end
      if (strb.lookup) begin
        lastHit <= nextLast;
        skipCnt <= camHit ? cwSkip : '0;
        if (camHit) prevTag <= cwUseTag ? cwTag : camHitAddr;
      end else if (strb.skip) begin
        skipCnt <= skipCnt - SKIP_W'(1);
      end
    end
  end

endmodule

// File: rtl/clsControl.sv
module clsControl
  import clsPkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      byteValid,
  input  logic      byteLast,
  input  clsStatusT stat,
  output clsStrobeT strb,
  output logic      draining
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} stateT;
  stateT state, stateNxt;
  logic  finish;

  always_comb begin
    strb     = '0;
    stateNxt = state;
    finish   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (byteValid) begin
          strb.lookup = 1'b1;
          strb.first  = 1'b1;
          finish      = !stat.hit || stat.done || byteLast;
        end
      end
      ST_RUN: begin
        if (byteValid) begin
          if (stat.skipPending) begin
            strb.skip = 1'b1;
            finish    = byteLast;
          end else begin
            strb.lookup = 1'b1;
            finish      = !stat.hit || stat.done || byteLast;
          end
        end
      end
      ST_DRAIN: begin
        if (byteValid && byteLast) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
    if (state != ST_DRAIN && byteValid) begin
      strb.emit = finish;
      if (!finish)      stateNxt = ST_RUN;
      else if (byteLast) stateNxt = ST_IDLE;
      else              stateNxt = ST_DRAIN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNxt;
  end

  assign draining = (state == ST_DRAIN);

endmodule

// File: rtl/camClassifier.sv
module camClassifier
  import clsPkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int BYTE_W  = 8,
  parameter int SKIP_W  = 4,
  localparam int ADDR_W = $clog2(ENTRIES),
  localparam int KEY_W  = ADDR_W + BYTE_W,
  localparam int CW_W   = 2 + ADDR_W + SKIP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              byteLast,
  input  logic              camWrEn,
  input  logic [ADDR_W-1:0] camWrAddr,
  input  logic              camWrValid,
  input  logic [KEY_W-1:0]  camWrKey,
  input  logic [KEY_W-1:0]  camWrMask,
  input  logic              ctlWrEn,
  input  logic [ADDR_W-1:0] ctlWrAddr,
  input  logic [CW_W-1:0]   ctlWrData,
  output logic              resultValid,
  output logic [ADDR_W-1:0] resultHit,
  output logic              resultMiss
);

  clsStrobeT strb;
  clsStatusT stat;
  logic      draining;

  clsControl ctl_i (
    .clk(clk), .rst(rst),
    .byteValid(byteValid), .byteLast(byteLast),
    .stat(stat), .strb(strb), .draining(draining)
  );

  clsDatapath #(.ENTRIES(ENTRIES), .BYTE_W(BYTE_W), .SKIP_W(SKIP_W)) dp_i (
    .clk(clk), .rst(rst), .byteData(byteData),
    .camWrEn(camWrEn), .camWrAddr(camWrAddr), .camWrValid(camWrValid),
    .camWrKey(camWrKey), .camWrMask(camWrMask),
    .ctlWrEn(ctlWrEn), .ctlWrAddr(ctlWrAddr), .ctlWrData(ctlWrData),
    .strb(strb), .stat(stat),
    .resultValid(resultValid), .resultHit(resultHit), .resultMiss(resultMiss)
  );

endmodule

// File: rtl/clsChecker.sv
module clsChecker (
  input logic clk,
  input logic rst,
  input logic byteValid,
  input logic byteLast,
  input logic resultValid,
  input logic resultMiss,
  input logic draining
);

  AST_MISS_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    resultMiss && resultValid |-> !$past(draining)); // R6

  AST_RESULT_HAS_BYTE: assert property (@(posedge clk) disable iff (rst)
    resultValid |-> $past(byteValid)); // R9

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
    byteValid && byteLast && !draining |=> resultValid); // R7

  AST_DRAIN_QUIET: assert property (@(posedge clk) disable iff (rst)
    draining |=> !resultValid); // R9

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> !resultValid); // R10

endmodule

bind camClassifier clsChecker chk_i (
  .clk(clk), .rst(rst), .byteValid(byteValid), .byteLast(byteLast),
  .resultValid(resultValid), .resultMiss(resultMiss), .draining(draining)
);

// File: tb/camClassifier_tb_top.sv
`timescale 1ns/1ps
module camClassifier_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        byteLast = 1'b0;
  logic        camWrEn = 1'b0;
  logic [4:0]  camWrAddr = '0;
  logic        camWrValid = 1'b0;
  logic [12:0] camWrKey = '0;
  logic [12:0] camWrMask = '0;
  logic        ctlWrEn = 1'b0;
  logic [4:0]  ctlWrAddr = '0;
  logic [10:0] ctlWrData = '0;
  logic        resultValid;
  logic [4:0]  resultHit;
  logic        resultMiss;

  int nTests = 0;
  int nFail  = 0;
  int vCount = 0;
  int vHit   = 0;
  int vMiss  = 0;
  logic [7:0] pkt [20];

  always #4 clk = ~clk;

  camClassifier dut_i (
    .clk(clk), .rst(rst), .byteValid(byteValid), .byteData(byteData), .byteLast(byteLast),
    .camWrEn(camWrEn), .camWrAddr(camWrAddr), .camWrValid(camWrValid),
    .camWrKey(camWrKey), .camWrMask(camWrMask),
    .ctlWrEn(ctlWrEn), .ctlWrAddr(ctlWrAddr), .ctlWrData(ctlWrData),
    .resultValid(resultValid), .resultHit(resultHit), .resultMiss(resultMiss)
  );

  always @(negedge clk) begin
    if (resultValid) begin
      vCount++;
      vHit  = int'(resultHit);
      vMiss = int'(resultMiss);
    end
  end

  task automatic chk(string req, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [10:0] cw(logic done, logic useTag, logic [4:0] tag, logic [3:0] skip);
    return {done, useTag, tag, skip};
  endfunction

  task automatic camWrite(int idx, logic en, logic [4:0] tag, logic [7:0] b, logic [12:0] mask);
    @(negedge clk);
    camWrEn = 1'b1; camWrAddr = 5'(idx); camWrValid = en;
    camWrKey = {tag, b}; camWrMask = mask;
    @(negedge clk);
    camWrEn = 1'b0;
  endtask

  task automatic ctlWrite(int idx, logic [10:0] d);
    @(negedge clk);
    ctlWrEn = 1'b1; ctlWrAddr = 5'(idx); ctlWrData = d;
    @(negedge clk);
    ctlWrEn = 1'b0;
  endtask

  task automatic clearAll();
    for (int i = 0; i < 32; i++) begin
      camWrite(i, 1'b0, 5'd0, 8'd0, 13'h0);
      ctlWrite(i, 11'd0);
    end
  endtask

  task automatic runPkt(int len);
    vCount = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      byteValid = 1'b1; byteData = pkt[i]; byteLast = (i == len - 1);
    end
    @(negedge clk);
    byteValid = 1'b0; byteLast = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic expectRes(string req, int hit, int miss);
    chk({req, " count"}, vCount, 1);
    chk({req, " hit"}, vHit, hit);
    chk({req, " miss"}, vMiss, miss);
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int expHit;
    repeat (3) @(negedge clk);
    chk("R10 strobe low in reset", int'(resultValid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 strobe low after reset", int'(resultValid), 0);

    // R10: empty table misses
    pkt[0] = 8'h00;
    runPkt(1);
    expectRes("R10 empty table", 0, 1);

    // R1/R5/R3: entries 0..30 exact on tag 0, entry 31 wildcard byte
    for (int i = 0; i < 31; i++) begin
      camWrite(i, 1'b1, 5'd0, 8'(i * 7 + 3), 13'h1FFF);
      ctlWrite(i, cw(1'b1, 1'b0, 5'd0, 4'd0));
    end
    camWrite(31, 1'b1, 5'd0, 8'h00, 13'h1F00);
    ctlWrite(31, cw(1'b1, 1'b0, 5'd0, 4'd0));
    for (int b = 0; b < 256; b++) begin
      if (b >= 3 && (b - 3) % 7 == 0 && (b - 3) / 7 < 31) expHit = (b - 3) / 7;
      else expHit = 31;
      pkt[0] = 8'(b);
      runPkt(1);
      expectRes("R3 R5 sweep", expHit, 0);
    end

    // R2: disabled entry never matches
    camWrite(31, 1'b0, 5'd0, 8'h00, 13'h1F00);
    pkt[0] = 8'd1;
    runPkt(1);
    expectRes("R2 disabled entry", 0, 1);

    // R2: ternary mask on upper nibble
    clearAll();
    camWrite(0, 1'b1, 5'd0, 8'hA0, 13'h1FF0);
    ctlWrite(0, cw(1'b1, 1'b0, 5'd0, 4'd0));
    for (int b = 0; b < 256; b++) begin
      pkt[0] = 8'(b);
      runPkt(1);
      expectRes("R2 ternary", 0, ((b >> 4) == 10) ? 0 : 1);
    end

    // R1/R4/R9: chain by hit index, trailing bytes ignored
    clearAll();
    camWrite(1, 1'b1, 5'd0, 8'h11, 13'h1FFF);
    ctlWrite(1, cw(1'b0, 1'b0, 5'd0, 4'd0));
    camWrite(2, 1'b1, 5'd1, 8'h22, 13'h1FFF);
    ctlWrite(2, cw(1'b1, 1'b0, 5'd0, 4'd0));
    camWrite(3, 1'b1, 5'd0, 8'h22, 13'h1FFF);
    ctlWrite(3, cw(1'b1, 1'b0, 5'd0, 4'd0));
    pkt[0] = 8'h11; pkt[1] = 8'h22; pkt[2] = 8'h11; pkt[3] = 8'h33;
    runPkt(4);
    expectRes("R4 R9 chain", 2, 0);
    // R1: new packet starts with tag zero
    pkt[0] = 8'h22;
    runPkt(1);
    expectRes("R1 restart tag zero", 3, 0);

    // R4: tag override
    camWrite(4, 1'b1, 5'd9, 8'h44, 13'h1FFF);
    ctlWrite(4, cw(1'b1, 1'b0, 5'd0, 4'd0));
    ctlWrite(1, cw(1'b0, 1'b1, 5'd9, 4'd0));
    pkt[0] = 8'h11; pkt[1] = 8'h44; pkt[2] = 8'h00;
    runPkt(3);
    expectRes("R4 override", 4, 0);
    pkt[0] = 8'h11; pkt[1] = 8'h22;
    runPkt(2);
    expectRes("R4 override not index", 1, 1);

    // R6: mid-packet miss reports last success
    ctlWrite(1, cw(1'b0, 1'b0, 5'd0, 4'd0));
    pkt[0] = 8'h11; pkt[1] = 8'h99; pkt[2] = 8'h22;
    runPkt(3);
    expectRes("R6 mid miss", 1, 1);

    // R7: last byte ends without done
    pkt[0] = 8'h11;
    runPkt(1);
    expectRes("R7 last ends", 1, 0);

    // R8: skip sweep
    for (int n = 0; n < 16; n++) begin
      ctlWrite(1, cw(1'b0, 1'b0, 5'd0, 4'(n)));
      pkt[0] = 8'h11;
      for (int k = 0; k < n; k++) pkt[1 + k] = 8'h99;
      pkt[1 + n] = 8'h22;
      pkt[2 + n] = 8'h33;
      runPkt(n + 3);
      expectRes("R8 skip sweep", 2, 0);
    end
    // R8: last byte inside skip window
    ctlWrite(1, cw(1'b0, 1'b0, 5'd0, 4'd3));
    pkt[0] = 8'h11; pkt[1] = 8'h99;
    runPkt(2);
    expectRes("R8 last in skip", 1, 0);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule